// File: doc/BRIEF.md
# Periodic Interval Timer with Auto-Reload

This block is a 16-bit down-counting interval timer that fires periodically. Software loads a start value through a byte-wide register bus, selects one of two tick periods (10 µs or 100 ms), and enables the timer. An internal prescaler divides the system clock into ticks. Each tick decrements the current count. The tick that arrives while the count is already zero reloads the count from the stored base value and raises an interrupt. A base value of B therefore gives one interrupt every B+1 ticks.

The interrupt flag is sticky and is cleared by writing one to its status bit. If the timer expires again before software clears the flag, a second sticky bit records the overrun. The base value can only be changed while the timer is stopped. The live count can be read at any time as a low byte and a high byte.

Register map. Reads of addresses 6 and 7 return zero, and writes to them have no effect.
- Address 0, control: bit 0 enables the timer, bit 1 selects the long period.
- Address 1, status: bit 0 is the interrupt flag, bit 1 is the overrun flag.
- Addresses 2 and 3: base count, low byte and high byte.
- Addresses 4 and 5: current count, low byte and high byte (read only).

Top module: `itimer_top`

## Requirements
- R1: After reset, every register (control, status, base, current) reads 0x00 and irq_o is low.
- R2: A write to address 2 or 3 while the timer is disabled replaces that byte of the base count. The whole resulting base value is copied into the current count on the same clock edge. The base count reads back at addresses 2 and 3, and the current count reads back at addresses 4 (low byte) and 5 (high byte).
- R3: Writes to addresses 2 or 3 while the timer is enabled leave both the base and the current count unchanged. Writes to addresses 4 and 5 have no effect.
- R4: While control bit 0 is 1, the current count drops by exactly one per tick. While control bit 0 is 0, the current count holds its value.
- R5: The tick period is CLK_HZ/100000 clock cycles (10 µs) when control bit 1 is 0, and CLK_HZ/10 clock cycles (100 ms) when control bit 1 is 1.
- R6: The prescaler restarts when the timer is enabled and when a control write changes bit 1. The first decrement after such a write lands exactly one full tick period after the write edge.
- R7: A tick that arrives while the current count is zero reloads the count from the base count and sets status bit 0. A base of B therefore gives one expiry every B+1 ticks.
- R8: Status bit 0 stays set until a write to address 1 with data bit 0 equal to 1. irq_o always equals status bit 0.
- R9: An expiry while status bit 0 is already set, and not being cleared in the same cycle, sets status bit 1. Status bit 1 stays set until a write to address 1 with data bit 1 equal to 1. If an expiry and a clear of bit 0 fall in the same cycle, bit 0 stays set and bit 1 is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, CLK_HZ |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe, one write per asserted cycle |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Timer interrupt, level, equals status bit 0 |

## Verification
A wrong prescaler phase shows at the count ports as a decrement that lands one or more cycles early or late. The bench samples the count on exact cycle boundaries after each enable, period-select change and restart, so such an error is caught within a single tick. A wrong reload value or missed expiry shifts every later count reading and the status bits within one base period. A wrongly cleared or wrongly set sticky flag appears on irq_o and the status register on the next read. The same-cycle clear-versus-expiry case is timed deliberately to expose a wrong priority.

// File: rtl/itimer_pkg.sv
package itimer_pkg;
  localparam int unsigned COUNT_W = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT    = 3'd1;
  localparam logic [ADDR_W-1:0] A_BASE_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_BASE_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CUR_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CUR_HI  = 3'd5;

  typedef struct packed {
    logic long_sel;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic ovr;
    logic irq;
  } stat_t;
endpackage

// File: rtl/itimer_prescaler.sv
module itimer_prescaler #(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  input  logic long_sel_i,
  output logic tick_o
);
  localparam int unsigned SHORT_DIV = CLK_HZ / 100_000;
  localparam int unsigned LONG_DIV  = CLK_HZ / 10;
  localparam int unsigned CNT_W     = $clog2(LONG_DIV + 1);
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_DIV - 1);
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = (cnt_q == (long_sel_i ? LONG_LIM : SHORT_LIM));
  assign tick_o = run_i && !restart_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i || restart_i)    cnt_q <= '0;
    else if (wrap)                   cnt_q <= '0;
    else                             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/itimer_counter.sv
module itimer_counter
  import itimer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [COUNT_W-1:0] load_val_i,
  input  logic [COUNT_W-1:0] base_i,
  output logic [COUNT_W-1:0] cur_o,
  output logic               expire_o
);
  logic [COUNT_W-1:0] cur_q;
  logic               at_zero;

  assign at_zero  = (cur_q == '0);
  assign expire_o = tick_i && at_zero;
  assign cur_o    = cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_q <= '0;
    else if (load_i)   cur_q <= load_val_i;
    else if (tick_i)   cur_q <= at_zero ? base_i : cur_q - 1'b1;
  end
endmodule

// File: rtl/itimer_regs.sv
module itimer_regs
  import itimer_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               expire_i,
  input  logic [COUNT_W-1:0] cur_i,
  output ctrl_t              ctrl_o,
  output logic               restart_o,
  output logic [COUNT_W-1:0] base_o,
  output logic               base_ld_o,
  output logic [COUNT_W-1:0] base_nxt_o,
  output stat_t              stat_o,
  output logic [DATA_W-1:0]  rdata_o
);
  ctrl_t              ctrl_q;
  stat_t              stat_q, stat_d;
  logic [COUNT_W-1:0] base_q;
  logic               ctrl_wr, stat_wr, lo_wr, hi_wr;
  logic               clr_irq, clr_ovr;

  assign ctrl_wr = wr_i && (addr_i == A_CTRL);
  assign stat_wr = wr_i && (addr_i == A_STAT);
  assign lo_wr   = wr_i && !ctrl_q.enable && (addr_i == A_BASE_LO);
  assign hi_wr   = wr_i && !ctrl_q.enable && (addr_i == A_BASE_HI);

  // period change restarts the prescaler; enable rising restarts via run low
  assign restart_o = ctrl_wr && (wdata_i[1] != ctrl_q.long_sel);

  always_comb begin
    base_nxt_o = base_q;
    if (lo_wr) base_nxt_o[7:0]          = wdata_i;
    if (hi_wr) base_nxt_o[COUNT_W-1:8]  = wdata_i;
  end
  assign base_ld_o = lo_wr || hi_wr;

  assign clr_irq = stat_wr && wdata_i[0];
  assign clr_ovr = stat_wr && wdata_i[1];

  always_comb begin
    stat_d.irq = expire_i || (stat_q.irq && !clr_irq);
    stat_d.ovr = (expire_i && stat_q.irq && !clr_irq) || (stat_q.ovr && !clr_ovr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
      base_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      stat_q <= stat_d;
      if (base_ld_o) base_q <= base_nxt_o;
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:    rdata_o = {6'd0, ctrl_q};
      A_STAT:    rdata_o = {6'd0, stat_q};
      A_BASE_LO: rdata_o = base_q[7:0];
      A_BASE_HI: rdata_o = base_q[COUNT_W-1:8];
      A_CUR_LO:  rdata_o = cur_i[7:0];
      A_CUR_HI:  rdata_o = cur_i[COUNT_W-1:8];
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign base_o = base_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/itimer_top.sv
module itimer_top
  import itimer_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  ctrl_t              ctrl;
  stat_t              stat;
  logic               restart, tick, expire, base_ld;
  logic [COUNT_W-1:0] base, base_nxt, cur;

  itimer_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .expire_i   (expire),
    .cur_i      (cur),
    .ctrl_o     (ctrl),
    .restart_o  (restart),
    .base_o     (base),
    .base_ld_o  (base_ld),
    .base_nxt_o (base_nxt),
    .stat_o     (stat),
    .rdata_o    (rdata_o)
  );

  itimer_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (ctrl.enable),
    .restart_i  (restart),
    .long_sel_i (ctrl.long_sel),
    .tick_o     (tick)
  );

  itimer_counter u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .load_i     (base_ld),
    .load_val_i (base_nxt),
    .base_i     (base),
    .cur_o      (cur),
    .expire_o   (expire)
  );

  assign irq_o = stat.irq;
endmodule

// File: rtl/itimer_chk.sv
module itimer_chk
  import itimer_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               irq_o,
  input logic               en_i,
  input logic               tick_i,
  input logic               base_ld_i,
  input logic [COUNT_W-1:0] cur_i,
  input logic [COUNT_W-1:0] base_i,
  input logic               irq_flag_i,
  input logic               ovr_flag_i
);
  logic clr0, clr1;
  assign clr0 = wr_i && (addr_i == A_STAT) && wdata_i[0];
  assign clr1 = wr_i && (addr_i == A_STAT) && wdata_i[1];

  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (cur_i != '0) |=> cur_i == $past(cur_i) - 1'b1);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !base_ld_i |=> $stable(cur_i));

  p_base_locked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> $stable(base_i));

  p_no_tick_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_i);

  p_reload_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && (cur_i == '0) |=> (cur_i == $past(base_i)) && irq_flag_i);

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_i && !clr0 |=> irq_flag_i);

  p_irq_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == irq_flag_i);

  p_overrun_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_flag_i && tick_i && (cur_i == '0) && !clr0 |=> ovr_flag_i);

  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_flag_i && !clr1 |=> ovr_flag_i);
endmodule

bind itimer_top itimer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .en_i       (ctrl.enable),
  .tick_i     (tick),
  .base_ld_i  (base_ld),
  .cur_i      (cur),
  .base_i     (base),
  .irq_flag_i (stat.irq),
  .ovr_flag_i (stat.ovr)
);

// File: tb/itimer_top_tb.sv
module itimer_top_tb;
  localparam int CLK_HZ = 400_000;
  localparam int SP = CLK_HZ / 100_000;
  localparam int LP = CLK_HZ / 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  itimer_top #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr_reg(input int a, input int d);
    wr = 1'b1; addr = 3'(a); wdata = 8'(d);
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input int a, output int v);
    addr = 3'(a);
    #1 v = int'(rdata);
  endtask

  task automatic rd16(input int lo, output int v);
    int l, h;
    rd_reg(lo, l);
    rd_reg(lo + 1, h);
    v = (h << 8) | l;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_base(input int b);
    wr_reg(0, 0);
    wr_reg(2, b & 8'hff);
    wr_reg(3, (b >> 8) & 8'hff);
  endtask

  function automatic int exp_cur(input int b, input int n);
    return b - (n % (b + 1));
  endfunction

  function automatic int exp_stat(input int b, input int n);
    int x;
    x = n / (b + 1);
    return (x > 0 ? 1 : 0) | (x > 1 ? 2 : 0);
  endfunction

  initial begin
    repeat (150_000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, v2, b, n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd_reg(a, v);
      chk("R1 reset reg", v, 0);
    end
    chk("R1 irq_o reset", int'(irq), 0);

    // R2 base write loads current
    load_base(16'hA55A);
    rd16(2, v);  chk("R2 base readback", v, 16'hA55A);
    rd16(4, v);  chk("R2 current loaded", v, 16'hA55A);

    // R3 writes to current ignored
    wr_reg(4, 8'h11); wr_reg(5, 8'h22);
    rd16(4, v);  chk("R3 current write ignored", v, 16'hA55A);

    // R3 base writes while enabled ignored (long period: no tick yet)
    wr_reg(0, 3);
    wr_reg(2, 8'h00); wr_reg(3, 8'h01);
    rd16(2, v);  chk("R3 base locked", v, 16'hA55A);
    rd16(4, v);  chk("R3 current untouched", v, 16'hA55A);

    // R5 long period: first decrement exactly LP cycles after enable
    load_base(1);
    wr_reg(0, 3);
    wait_cyc(LP - 1);
    rd16(4, v);  chk("R5 long period not yet", v, 1);
    wait_cyc(1);
    rd16(4, v);  chk("R5 long period tick", v, 0);

    // R6 restart on period change
    load_base(100);
    wr_reg(0, 1);
    wait_cyc(2);
    wr_reg(0, 3);
    wr_reg(0, 1);
    wait_cyc(SP - 1);
    rd16(4, v);  chk("R6 restart delays tick", v, 100);
    wait_cyc(1);
    rd16(4, v);  chk("R6 first tick after full period", v, 99);

    // R4 disabled holds
    wr_reg(0, 0);
    rd16(4, v);
    wait_cyc(5 * SP);
    rd16(4, v2); chk("R4 hold while disabled", v2, v);

    // R9 expiry and clear in the same cycle: irq stays, no overrun
    load_base(0);
    wr_reg(1, 3);
    wr_reg(0, 1);
    wait_cyc(2 * SP - 1);
    wr_reg(1, 1);
    rd_reg(1, v); chk("R9 set wins over clear", v, 1);
    wait_cyc(SP);
    rd_reg(1, v); chk("R9 overrun on second expiry", v, 3);
    wr_reg(1, 1);
    rd_reg(1, v); chk("R9 overrun sticky after irq clear", v, 2);
    chk("R8 irq_o low after clear", int'(irq), 0);
    wr_reg(0, 0);
    wr_reg(1, 2);
    rd_reg(1, v); chk("R9 overrun cleared", v, 0);

    // random: R4 R7 R8 R9 with exact tick timing (R5, R6)
    for (int i = 0; i < 24; i++) begin
      b = ($urandom % 4 == 0) ? 16'h1200 + int'($urandom % 256) : int'($urandom % 21);
      n = int'($urandom % 61);
      load_base(b);
      wr_reg(1, 3);
      wr_reg(0, 1);
      wait_cyc(SP * n);
      rd16(4, v);  chk("R4 R7 count after ticks", v, exp_cur(b, n));
      rd_reg(1, v); chk("R7 R9 status", v, exp_stat(b, n));
      chk("R8 irq_o", int'(irq), exp_stat(b, n) & 1);
      wr_reg(0, 0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule